// File: doc/BRIEF.md
# E1 Frame Alignment Engine

This block finds time slot 0 in a serial 2048 kb/s E1 stream and then stays aligned to it. Each frame holds 32 slots of 8 bits, and frames come in even/odd pairs of 512 bits. One bit enters per cycle in which `bit_en` is high. While hunting, a 7-bit sliding window is compared against the alignment word on every bit. A hit starts a confirmation: one frame later, bit 2 of the odd frame's slot 0 must be 1, and one frame after that the alignment word must appear again. Once confirmed, the engine free-runs a 512-bit position counter and watches the two checked fields for repeated errors.

The position of the next expected bit is given as an odd/even frame flag, a slot number and a bit number. The engine also gives a slot 0 strobe and a loss-of-frame flag. A neighbouring multiframe/CRC monitor can pulse `resync` when it judges the alignment spurious, for example after 915 errored CRC blocks in 1000. The new hunt then passes over the rejected position once. `soft_rst` drops alignment and starts a plain hunt.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset `lof` is 1 and `ts0_strobe` is 0.
- R2: The alignment word is 0011011, carried in bits 2..8 of slot 0 of even frames (frame-pair positions 1..7, bit 2 first). Acquisition needs three things in order: the word; a 1 at position 257 (bit 2 of the odd frame's slot 0); and the word again 512 bits after the first. `lof` falls in the cycle after the bit at position 7 that completes the second word. A clean stream that starts at position 0 right after reset therefore locks after 520 bits.
- R3: If either confirmation step fails, hunting resumes at once. The failed candidate position is not accepted on its next appearance 512 bits later, and is accepted after that.
- R4: While locked, {`odd_frame`,`slot_num`,`bit_num`} equals the frame-pair position (0..511) of the next bit to arrive. `ts0_strobe` is 1 exactly when locked and `slot_num` is 0.
- R5: While locked, an incorrect alignment word on three consecutive even frames sets `lof` after the third. A correct word in between restarts the count.
- R6: While locked, a 0 at position 257 on three consecutive odd frames sets `lof` after the third.
- R7: A `resync` pulse sets `lof` in the next cycle. The hunt that follows skips the old alignment position once.
- R8: A `soft_rst` pulse sets `lof` in the next cycle and starts a hunt that skips nothing.
- R9: With `bit_en` low, neither the position nor `lof` changes.
- R10: After a loss caused by alignment word errors on an otherwise clean stream, lock returns within 1031 bits (about 500 us).
- R11: While locked, payload bits, bit 1 of slot 0 and bits 3..8 of odd frames' slot 0 have no effect on alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit valid this cycle |
| rx_bit | input | 1 | Received serial data bit |
| resync | input | 1 | Pulse from multiframe monitor: alignment judged spurious |
| soft_rst | input | 1 | Pulse: drop alignment and hunt afresh |
| lof | output | 1 | Loss of frame alignment |
| odd_frame | output | 1 | Next bit belongs to the odd frame of the pair |
| slot_num | output | 5 | Time slot of the next bit |
| bit_num | output | 3 | Bit index within the slot of the next bit (0 = bit 1) |
| ts0_strobe | output | 1 | Locked and next bit is in slot 0 |

## Verification
The assertions check on every cycle that the position and `lof` freeze when no bit is offered. They also check that a locked counter advances by exactly one per bit, that both `resync` and `soft_rst` raise `lof` in the next cycle, and that lock is only ever declared right after the bit that closes an alignment word. Only the bench scenarios can show the acquisition cycle counts, the three-in-a-row loss rules and their counter restart, the one-pass skip after a failed confirmation or a resync, and the immunity of alignment to payload and spare slot 0 bits.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
    localparam int SLOT_BITS       = 8;
    localparam int SLOTS_PER_FRAME = 32;
    localparam int FRAME_BITS      = SLOT_BITS * SLOTS_PER_FRAME;
    localparam int PAIR_BITS       = 2 * FRAME_BITS;
    localparam int POS_W           = $clog2(PAIR_BITS);
    localparam int SLOT_W          = $clog2(SLOTS_PER_FRAME);
    localparam int BIT_W           = $clog2(SLOT_BITS);

    localparam int             ALIGN_LEN  = 7;
    localparam logic [ALIGN_LEN-1:0] ALIGN_WORD = 7'b0011011;

    // Pair position of the last bit of the alignment word, first bit after it,
    // and of bit 2 in the odd frame's slot 0.
    localparam int WORD_END_POS = ALIGN_LEN;
    localparam int LOCK_POS     = WORD_END_POS + 1;
    localparam int ODD_B2_POS   = FRAME_BITS + 1;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic              odd;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_fields_t;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CONF_ODD,
        ST_CONF_WORD,
        ST_LOCKED
    } align_state_e;

    function automatic pos_t pos_const(input int v);
        return pos_t'(v);
    endfunction
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window
    import e1fa_pkg::*;
#(
    parameter int                 LEN     = ALIGN_LEN,
    parameter logic [LEN-1:0]     PATTERN = ALIGN_WORD
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic din,
    output logic hit
);
    logic [LEN-1:0] win_q;
    logic [LEN-1:0] win_nxt;

    assign win_nxt = {win_q[LEN-2:0], din};
    assign hit     = (win_nxt == PATTERN);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= win_nxt;
        end
    end
endmodule

// File: rtl/e1fa_pos_counter.sv
module e1fa_pos_counter
    import e1fa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  pos_t load_val,
    output pos_t pos
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (load) begin
            pos <= load_val;
        end else if (adv) begin
            pos <= pos + pos_t'(1);
        end
    end
endmodule

// File: rtl/e1fa_err_run.sv
module e1fa_err_run #(
    parameter int LIMIT = 3,
    localparam int RUN_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic strobe,
    input  logic err,
    output logic trip
);
    logic [RUN_W-1:0] run_q;

    assign trip = strobe && err && (run_q == RUN_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (strobe) begin
            if (!err || trip) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end
endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int LOSS_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              resync,
    input  logic              soft_rst,
    output logic              lof,
    output logic              odd_frame,
    output logic [SLOT_W-1:0] slot_num,
    output logic [BIT_W-1:0]  bit_num,
    output logic              ts0_strobe
);
    localparam int N_MON = 2;   // 0: alignment word, 1: odd-frame bit 2

    align_state_e state_q, state_n;
    logic         skip_q, skip_n;
    pos_t         pos;
    logic         word_hit;
    logic         at_word_end, at_odd_b2;
    logic         hunt_take;
    logic [N_MON-1:0] mon_strobe, mon_err, mon_trip;
    pos_fields_t  pf;

    e1fa_window u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_en),
        .din      (rx_bit),
        .hit      (word_hit)
    );

    assign at_word_end = (pos == pos_const(WORD_END_POS));
    assign at_odd_b2   = (pos == pos_const(ODD_B2_POS));

    assign hunt_take = (state_q == ST_HUNT) && bit_en && word_hit
                     && !(skip_q && at_word_end) && !resync && !soft_rst;

    e1fa_pos_counter u_pos (
        .clk      (clk),
        .rst      (rst),
        .adv      (bit_en),
        .load     (hunt_take),
        .load_val (pos_const(LOCK_POS)),
        .pos      (pos)
    );

    assign mon_strobe[0] = (state_q == ST_LOCKED) && bit_en && at_word_end;
    assign mon_err[0]    = !word_hit;
    assign mon_strobe[1] = (state_q == ST_LOCKED) && bit_en && at_odd_b2;
    assign mon_err[1]    = !rx_bit;

    for (genvar m = 0; m < N_MON; m++) begin : g_mon
        e1fa_err_run #(.LIMIT(LOSS_LIMIT)) u_run (
            .clk    (clk),
            .rst    (rst),
            .clear  (state_q != ST_LOCKED),
            .strobe (mon_strobe[m]),
            .err    (mon_err[m]),
            .trip   (mon_trip[m])
        );
    end

    always_comb begin
        state_n = state_q;
        skip_n  = skip_q;
        if (soft_rst) begin
            state_n = ST_HUNT;
            skip_n  = 1'b0;
        end else if (resync) begin
            state_n = ST_HUNT;
            skip_n  = 1'b1;
        end else if (bit_en) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (at_word_end) skip_n = 1'b0;
                    if (hunt_take)   state_n = ST_CONF_ODD;
                end
                ST_CONF_ODD: begin
                    if (at_odd_b2) begin
                        if (rx_bit) begin
                            state_n = ST_CONF_WORD;
                        end else begin
                            state_n = ST_HUNT;
                            skip_n  = 1'b1;
                        end
                    end
                end
                ST_CONF_WORD: begin
                    if (at_word_end) begin
                        if (word_hit) begin
                            state_n = ST_LOCKED;
                        end else begin
                            state_n = ST_HUNT;
                            skip_n  = 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (|mon_trip) begin
                        state_n = ST_HUNT;
                        skip_n  = 1'b0;
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            skip_q  <= skip_n;
        end
    end

    assign pf         = pos_fields_t'(pos);
    assign lof        = (state_q != ST_LOCKED);
    assign odd_frame  = pf.odd;
    assign slot_num   = pf.slot;
    assign bit_num    = pf.bitn;
    assign ts0_strobe = !lof && (pf.slot == '0);
endmodule

// File: rtl/e1fa_checker.sv
module e1fa_checker
    import e1fa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              resync,
    input logic              soft_rst,
    input logic              lof,
    input logic              odd_frame,
    input logic [SLOT_W-1:0] slot_num,
    input logic [BIT_W-1:0]  bit_num
);
    pos_t cur_pos;
    assign cur_pos = {odd_frame, slot_num, bit_num};

    // R9: nothing moves without a bit
    p_frozen_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !resync && !soft_rst) |=> ($stable(cur_pos) && $stable(lof)));

    // R4: locked counter steps by one per bit
    p_step_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !lof) |=> (lof || cur_pos == pos_t'($past(cur_pos) + pos_t'(1))));

    // R7: resync drops alignment
    p_resync_drop_r7: assert property (@(posedge clk) disable iff (rst)
        resync |=> lof);

    // R8: soft reset drops alignment
    p_softrst_drop_r8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> lof);

    // R2: lock only right after the bit closing an alignment word
    p_lock_point_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(lof) |-> (cur_pos == pos_const(LOCK_POS)));
endmodule

bind e1_frame_aligner e1fa_checker u_e1fa_checker (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .resync    (resync),
    .soft_rst  (soft_rst),
    .lof       (lof),
    .odd_frame (odd_frame),
    .slot_num  (slot_num),
    .bit_num   (bit_num)
);

// File: tb/e1_frame_aligner_tb_top.sv
module e1_frame_aligner_tb_top;
    import e1fa_pkg::*;

    logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, rx_bit = 1'b0;
    logic resync = 1'b0, soft_rst = 1'b0;
    logic lof, odd_frame, ts0_strobe;
    logic [4:0] slot_num;
    logic [2:0] bit_num;

    int  checks = 0, fails = 0, gpos = 0;
    bit  cor_word = 0, cor_odd = 0, noisy = 0, done = 0;

    always #2 clk = ~clk;

    e1_frame_aligner dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .resync(resync), .soft_rst(soft_rst), .lof(lof),
        .odd_frame(odd_frame), .slot_num(slot_num), .bit_num(bit_num),
        .ts0_strobe(ts0_strobe)
    );

    function automatic int dut_pos();
        return {23'd0, odd_frame, slot_num, bit_num};
    endfunction

    function automatic logic gen(int p);
        int q = p % 256;
        bit odd = (p >= 256);
        if (q == 0) return noisy ? logic'($urandom % 2) : 1'b1;
        if (!odd && q < 8) return ALIGN_WORD[7 - q] ^ (cor_word && q == 4);
        if (odd && q == 1) return !cor_odd;
        if (odd && q < 8) return noisy ? logic'($urandom % 2) : (q != 2);
        if (noisy) return logic'($urandom % 2);
        return ((q >> 3) & 1) ? 1'b1 : logic'(q & 1);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_bit();
        @(negedge clk);
        rx_bit = gen(gpos);
        bit_en = 1'b1;
        @(posedge clk);
        #1;
        bit_en = 1'b0;
        gpos = (gpos + 1) % 512;
    endtask

    task automatic send_n(int n);
        for (int i = 0; i < n; i++) send_bit();
    endtask

    task automatic send_to(int target);
        do send_bit(); while (gpos != target);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; gpos = 0; cor_word = 0; cor_odd = 0; noisy = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic lock_up();
        do_reset();
        send_n(520);
    endtask

    task automatic pulse(bit is_resync);
        @(negedge clk);
        if (is_resync) resync = 1'b1; else soft_rst = 1'b1;
        @(posedge clk);
        #1;
        resync = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(lof == 1'b1, "R1 lof after reset", lof, 1);
        chk(ts0_strobe == 1'b0, "R1 ts0_strobe after reset", ts0_strobe, 0);
    endtask

    task automatic t_acquire();
        do_reset();
        send_n(519);
        chk(lof == 1'b1, "R2 lof one bit before lock", lof, 1);
        send_bit();
        chk(lof == 1'b0, "R2 lof at lock", lof, 0);
        chk(dut_pos() == gpos, "R2 position at lock", dut_pos(), gpos);
    endtask

    task automatic t_position();
        int bad_pos = 0, bad_ts0 = 0;
        lock_up();
        for (int i = 0; i < 512; i++) begin
            send_bit();
            if (dut_pos() != gpos) bad_pos++;
            if (ts0_strobe != ((gpos % 256) < 8)) bad_ts0++;
        end
        chk(bad_pos == 0, "R4 position tracking errors", bad_pos, 0);
        chk(bad_ts0 == 0, "R4 ts0_strobe errors", bad_ts0, 0);
    endtask

    task automatic t_ignore();
        int bad = 0;
        lock_up();
        noisy = 1;
        for (int i = 0; i < 1024; i++) begin
            send_bit();
            if (lof || dut_pos() != gpos) bad++;
        end
        noisy = 0;
        chk(bad == 0, "R11 alignment disturbed by spare bits", bad, 0);
    endtask

    task automatic t_word_loss();
        int n = 0;
        lock_up();
        cor_word = 1; send_to(8); send_to(8);
        cor_word = 0; send_to(8);
        cor_word = 1; send_to(8); send_to(8);
        chk(lof == 1'b0, "R5 good word restarts error run", lof, 0);
        send_to(8);
        chk(lof == 1'b1, "R5 lof after third bad word", lof, 1);
        cor_word = 0;
        while (lof && n < 1100) begin send_bit(); n++; end
        chk(n <= 1031, "R10 relock bit count", n, 1024);
        chk(dut_pos() == gpos, "R10 relock position", dut_pos(), gpos);
    endtask

    task automatic t_odd_loss();
        lock_up();
        cor_odd = 1;
        send_to(258); send_to(258);
        chk(lof == 1'b0, "R6 two bad odd bits keep lock", lof, 0);
        send_to(258);
        chk(lof == 1'b1, "R6 lof after third bad odd bit", lof, 1);
        cor_odd = 0;
    endtask

    task automatic t_confirm_fail();
        do_reset();
        cor_odd = 1; send_to(258);
        cor_odd = 0;
        send_to(8);
        chk(lof == 1'b1, "R3 failed candidate skipped once", lof, 1);
        send_to(8);
        chk(lof == 1'b1, "R3 candidate re-taken, confirming", lof, 1);
        send_to(8);
        chk(lof == 1'b0, "R3 lock after skip pass", lof, 0);
    endtask

    task automatic t_resync();
        lock_up();
        send_to(100);
        pulse(1'b1);
        chk(lof == 1'b1, "R7 lof after resync", lof, 1);
        send_to(8); send_to(8);
        chk(lof == 1'b1, "R7 old position skipped once", lof, 1);
        send_to(8);
        chk(lof == 1'b0, "R7 relock after skip", lof, 0);
        chk(dut_pos() == gpos, "R7 position after relock", dut_pos(), gpos);
    endtask

    task automatic t_softrst();
        lock_up();
        send_to(100);
        pulse(1'b0);
        chk(lof == 1'b1, "R8 lof after soft reset", lof, 1);
        send_to(8); send_to(8);
        chk(lof == 1'b0, "R8 relock without skip", lof, 0);
    endtask

    task automatic t_stall();
        lock_up();
        send_n(37);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_bit = i[0];
        end
        #1;
        chk(dut_pos() == gpos, "R9 position frozen", dut_pos(), gpos);
        chk(lof == 1'b0, "R9 lof frozen", lof, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_acquire();
        t_position();
        t_ignore();
        t_word_loss();
        t_odd_loss();
        t_confirm_fail();
        t_resync();
        t_softrst();
        t_stall();
        done = 1;
        summary();
        $finish;
    end
endmodule